// File: doc/BRIEF.md
# Four-Channel Match Timer with Watchdog Reset

The block keeps a 32-bit up-counter that advances by one in every cycle where the tick-enable input is high. Four channels each compare a programmable 32-bit match value against the counter. When an increment brings the counter onto a channel's match value, and that channel's interrupt gate is open, the channel's status flag is set. Each channel drives its own interrupt line, and that line follows the flag.

Software clears flags by writing ones to the status register. A clear touches only flags that are currently set, and an increment-driven set in the same cycle takes priority over the clear. The last channel doubles as a watchdog. If the watchdog arm bit is set when that channel matches, the block issues a one-cycle reset request and disarms itself. All registers are reached over a simple single-cycle request bus. Read data and the error flag come back on the cycle after the request.

Top module: `match_timer`

## Requirements
- R1: After reset the counter, the four match registers, the status flags, the interrupt enable register and the watchdog arm bit all read 0, and `irq` and `rst_req` are low.
- R2: The counter rises by exactly 1 on each clock edge where `tick_en` is high, holds its value when `tick_en` is low, and wraps from 0xFFFFFFFF to 0.
- R3: A bus write to the counter (offset 0x10) loads the written value and overrides a tick in the same cycle. Counting then continues from the loaded value. A load never counts as a match.
- R4: When an increment makes the counter equal to channel n's match value and interrupt enable bit n is 1, status bit n and `irq[n]` are high from that same edge. When enable bit n is 0, the match leaves status bit n and `irq[n]` low.
- R5: A write to the status register (offset 0x14) clears each flag whose data bit and current flag are both 1, and `irq[n]` falls with it. Flags whose data bit is 0 stay as they are, and data ones at flags that are 0 have no effect.
- R6: When a channel matches in the same cycle as a status write that would clear its flag, the flag ends up set.
- R7: When the watchdog arm bit (offset 0x18, bit 0) is 1 and channel 3 matches, `rst_req` is high for exactly one cycle and the arm bit reads 0 afterwards. This happens whatever interrupt enable bit 3 holds. With the arm bit at 0, a channel 3 match gives no request.
- R8: The interrupt enable register (offset 0x1C) keeps bits 11:0 of a write and reads the upper bits as 0. The watchdog register keeps only bit 0.
- R9: Match registers 0 to 3 sit at offsets 0x00, 0x04, 0x08 and 0x0C. A read request returns its data on `bus_rdata` in the cycle after the request, with `bus_err` low. The counter read returns the value before that edge.
- R10: A read of any other offset, including a misaligned one, returns 0 with `bus_err` high for one cycle. A write to such an offset changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Counter advance enable |
| bus_sel | input | 1 | Bus request valid |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read request |
| bus_err | output | 1 | One-cycle error pulse for an unmapped read |
| irq | output | 4 | Per-channel interrupt lines, equal to the status flags |
| rst_req | output | 1 | One-cycle watchdog reset request |

## Verification
A flag that is wrongly set or stuck shows at once on `irq`, with no bus access needed. A wrong counter value or match register only shows when an expected `irq` edge fails to arrive on the predicted tick, or when a read returns a different value one cycle after the request. A watchdog arm bit that failed to clear would show as a second `rst_req` pulse on the next channel 3 match. The bench therefore compares `irq` and `rst_req` on the exact cycle after each tick burst, and it reads back the registers after every store that should have been ignored.

// File: rtl/mtim_pkg.sv
package mtim_pkg;
  localparam int unsigned OFF_MATCH0 = 32'h00;
  localparam int unsigned OFF_COUNT  = 32'h10;
  localparam int unsigned OFF_STATUS = 32'h14;
  localparam int unsigned OFF_WDARM  = 32'h18;
  localparam int unsigned OFF_INTEN  = 32'h1C;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_MATCH,
    SEL_COUNT,
    SEL_STATUS,
    SEL_WDARM,
    SEL_INTEN
  } reg_sel_e;
endpackage

// File: rtl/mtim_counter.sv
module mtim_counter #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          ld,
  input  logic [CW-1:0] ld_val,
  output logic          inc,
  output logic [CW-1:0] cnt_nxt,
  output logic [CW-1:0] cnt
);
  logic [CW-1:0] cnt_n;

  always_comb begin
    inc     = tick_en && !ld;
    cnt_nxt = cnt + CW'(1);
    cnt_n   = cnt;
    if (ld)
      cnt_n = ld_val;
    else if (tick_en)
      cnt_n = cnt_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else
      cnt <= cnt_n;
  end

  // R2: a tick without a load advances by one (wraps naturally)
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !ld) |=> cnt == $past(cnt) + CW'(1));
  // R2: no tick and no load holds the value
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !ld) |=> $stable(cnt));
  // R3: a load wins over a tick
  a_r3_load: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> cnt == $past(ld_val));
endmodule

// File: rtl/mtim_channel.sv
module mtim_channel #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_match,
  input  logic [CW-1:0] wdata,
  input  logic          inc,
  input  logic [CW-1:0] cnt_nxt,
  input  logic          ien_bit,
  input  logic          clr_bit,
  output logic          hit,
  output logic [CW-1:0] match_q,
  output logic          flag
);
  logic [CW-1:0] match_n;
  logic          flag_n;

  always_comb begin
    hit     = inc && (cnt_nxt == match_q);
    match_n = wr_match ? wdata : match_q;
    // set has priority over a same-cycle clear
    flag_n  = (flag && !clr_bit) || (hit && ien_bit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_q <= '0;
      flag    <= 1'b0;
    end else begin
      match_q <= match_n;
      flag    <= flag_n;
    end
  end

  // R4: a flag only rises through an enabled match
  a_r4_gated: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(ien_bit && hit));
  // R5: a flag only falls through a status clear-write
  a_r5_clear_src: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> $past(clr_bit));
  // R6: an enabled match always leaves the flag set
  a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && ien_bit) |=> flag);
endmodule

// File: rtl/mtim_regs.sv
module mtim_regs
  import mtim_pkg::*;
#(
  parameter int CW    = 32,
  parameter int NCH   = 4,
  parameter int AW    = 8,
  parameter int IEN_W = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sel,
  input  logic                    we,
  input  logic [AW-1:0]           addr,
  input  logic [CW-1:0]           wdata,
  input  logic [CW-1:0]           cnt,
  input  logic [NCH-1:0][CW-1:0]  match_q,
  input  logic [NCH-1:0]          flags,
  input  logic                    hit_wd,
  output logic                    ld,
  output logic [CW-1:0]           ld_val,
  output logic [NCH-1:0]          wr_match,
  output logic [NCH-1:0]          stat_clr,
  output logic [IEN_W-1:0]        ien,
  output logic [CW-1:0]           rdata,
  output logic                    err,
  output logic                    rst_req
);
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1;

  reg_sel_e       rsel;
  logic [IW-1:0]  midx;
  logic [IEN_W-1:0] ien_n;
  logic           wdarm, wdarm_n;
  logic [CW-1:0]  rdata_n;
  logic           err_n, rst_req_n;
  logic           wr, rd;

  // address decode
  always_comb begin
    rsel = SEL_NONE;
    midx = '0;
    for (int i = 0; i < NCH; i++) begin
      if (addr == AW'(OFF_MATCH0 + 4 * i)) begin
        rsel = SEL_MATCH;
        midx = IW'(i);
      end
    end
    if (addr == AW'(OFF_COUNT))  rsel = SEL_COUNT;
    if (addr == AW'(OFF_STATUS)) rsel = SEL_STATUS;
    if (addr == AW'(OFF_WDARM))  rsel = SEL_WDARM;
    if (addr == AW'(OFF_INTEN))  rsel = SEL_INTEN;
  end

  always_comb begin
    wr       = sel && we;
    rd       = sel && !we;
    ld       = wr && (rsel == SEL_COUNT);
    ld_val   = wdata;
    wr_match = '0;
    if (wr && rsel == SEL_MATCH)
      wr_match[midx] = 1'b1;
    stat_clr = (wr && rsel == SEL_STATUS) ? wdata[NCH-1:0] : '0;

    ien_n = ien;
    if (wr && rsel == SEL_INTEN)
      ien_n = wdata[IEN_W-1:0];

    wdarm_n = wdarm;
    if (wr && rsel == SEL_WDARM)
      wdarm_n = wdata[0];
    rst_req_n = hit_wd && wdarm;
    if (rst_req_n)
      wdarm_n = 1'b0;

    rdata_n = rdata;
    err_n   = 1'b0;
    if (rd) begin
      unique case (rsel)
        SEL_MATCH:  rdata_n = match_q[midx];
        SEL_COUNT:  rdata_n = cnt;
        SEL_STATUS: rdata_n = CW'(flags);
        SEL_WDARM:  rdata_n = CW'(wdarm);
        SEL_INTEN:  rdata_n = CW'(ien);
        default: begin
          rdata_n = '0;
          err_n   = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien     <= '0;
      wdarm   <= 1'b0;
      rdata   <= '0;
      err     <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      ien     <= ien_n;
      wdarm   <= wdarm_n;
      rdata   <= rdata_n;
      err     <= err_n;
      rst_req <= rst_req_n;
    end
  end

  // R7: the request is a single-cycle pulse
  a_r7_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);
  // R7: the arm bit is clear once the request is out
  a_r7_disarm: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> !wdarm);
  // R10: an error response carries zero data
  a_r10_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> rdata == '0);
  // R9: read data only changes in answer to a read request
  a_r9_rdata_src: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rd) |-> $stable(rdata));
endmodule

// File: rtl/match_timer.sv
module match_timer #(
  parameter int CW    = 32,
  parameter int NCH   = 4,
  parameter int AW    = 8,
  parameter int IEN_W = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick_en,
  input  logic           bus_sel,
  input  logic           bus_we,
  input  logic [AW-1:0]  bus_addr,
  input  logic [CW-1:0]  bus_wdata,
  output logic [CW-1:0]  bus_rdata,
  output logic           bus_err,
  output logic [NCH-1:0] irq,
  output logic           rst_req
);
  localparam int WD_CH = NCH - 1;

  logic                   inc, ld;
  logic [CW-1:0]          cnt, cnt_nxt, ld_val;
  logic [NCH-1:0][CW-1:0] match_q;
  logic [NCH-1:0]         flags, hits, wr_match, stat_clr;
  logic [IEN_W-1:0]       ien;

  mtim_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .ld(ld), .ld_val(ld_val),
    .inc(inc), .cnt_nxt(cnt_nxt), .cnt(cnt)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    mtim_channel #(.CW(CW)) u_ch (
      .clk(clk), .rst_n(rst_n), .wr_match(wr_match[g]), .wdata(bus_wdata),
      .inc(inc), .cnt_nxt(cnt_nxt), .ien_bit(ien[g]), .clr_bit(stat_clr[g]),
      .hit(hits[g]), .match_q(match_q[g]), .flag(flags[g])
    );
  end

  mtim_regs #(.CW(CW), .NCH(NCH), .AW(AW), .IEN_W(IEN_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .sel(bus_sel), .we(bus_we), .addr(bus_addr),
    .wdata(bus_wdata), .cnt(cnt), .match_q(match_q), .flags(flags),
    .hit_wd(hits[WD_CH]), .ld(ld), .ld_val(ld_val), .wr_match(wr_match),
    .stat_clr(stat_clr), .ien(ien), .rdata(bus_rdata), .err(bus_err),
    .rst_req(rst_req)
  );

  assign irq = flags;

  // R1: outputs are quiet in the first cycle after reset release
  a_r1_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (irq == '0 && !rst_req));
endmodule

// File: tb/sim_match_timer.sv
`timescale 1ns/100ps
module sim_match_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        sel = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        err;
  logic [3:0]  irq;
  logic        rst_req;

  always #2.5 clk = ~clk;

  match_timer u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_sel(sel), .bus_we(we),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .bus_err(err),
    .irq(irq), .rst_req(rst_req)
  );

  localparam logic [7:0] A_M0 = 8'h00, A_M1 = 8'h04, A_M2 = 8'h08, A_M3 = 8'h0C;
  localparam logic [7:0] A_CNT = 8'h10, A_ST = 8'h14, A_WD = 8'h18, A_IE = 8'h1C;

  typedef struct {
    logic [31:0] data;
    logic        err;
    string       tag;
  } exp_t;
  exp_t sb[$];

  int checks = 0, errors = 0, wd_pulses = 0;
  bit done = 1'b0;
  logic rd_d = 1'b0;

  always_ff @(posedge clk) rd_d <= sel && !we;

  // monitor: pops one expected item per read response
  always @(negedge clk) begin
    if (rd_d) begin
      checks++;
      if (sb.size() == 0) begin
        errors++;
        $display("FAIL unexpected read response: rdata=%h err=%b expected none", rdata, err);
      end else begin
        exp_t e;
        e = sb.pop_front();
        if (rdata !== e.data || err !== e.err) begin
          errors++;
          $display("FAIL %s: rdata=%h err=%b expected %h/%b", e.tag, rdata, err, e.data, e.err);
        end
      end
    end
    if (rst_n && rst_req) wd_pulses++;
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input bit tk = 1'b0);
    sel = 1'b1; we = 1'b1; addr = a; wdata = d; tick_en = tk;
    @(negedge clk);
    sel = 1'b0; we = 1'b0; tick_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] d, input logic e, input string tag);
    exp_t x;
    x.data = d; x.err = e; x.tag = tag;
    sb.push_back(x);
    sel = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    sel = 1'b0;
  endtask

  task automatic tick(input int n);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", 32'(irq), 0);
    chk("R1 rst_req", 32'(rst_req), 0);
    rd(A_CNT, 0, 0, "R1 counter");
    rd(A_M0, 0, 0, "R1 match0");
    rd(A_M3, 0, 0, "R1 match3");
    rd(A_ST, 0, 0, "R1 status");
    rd(A_IE, 0, 0, "R1 inten");
    rd(A_WD, 0, 0, "R1 wdarm");

    // R8 register widths
    wr(A_IE, 32'hFFFF_FFFF);
    rd(A_IE, 32'h0000_0FFF, 0, "R8 inten width");
    wr(A_WD, 32'hFFFF_FFFE);
    rd(A_WD, 0, 0, "R8 wdarm bit0 only");
    wr(A_WD, 32'h3);
    rd(A_WD, 1, 0, "R8 wdarm set");
    wr(A_WD, 0);

    // R9 address map
    wr(A_M0, 5); wr(A_M1, 10); wr(A_M2, 7); wr(A_M3, 100);
    rd(A_M0, 5, 0, "R9 match0");
    rd(A_M1, 10, 0, "R9 match1");
    rd(A_M2, 7, 0, "R9 match2");
    rd(A_M3, 100, 0, "R9 match3");

    // R4 gated matches, R3 load
    wr(A_IE, 32'h5);
    wr(A_CNT, 0);
    tick(5);
    chk("R4 ch0 irq", 32'(irq), 32'h1);
    rd(A_ST, 1, 0, "R4 status ch0");
    tick(2);
    chk("R4 ch2 irq", 32'(irq), 32'h5);
    tick(3);
    chk("R4 ch1 gated off", 32'(irq), 32'h5);
    rd(A_CNT, 10, 0, "R2 count 10");
    repeat (3) @(negedge clk);
    rd(A_CNT, 10, 0, "R2 hold without tick");

    // R5 write-one-to-clear
    wr(A_ST, 32'hA);
    rd(A_ST, 5, 0, "R5 clear of unset bits");
    wr(A_ST, 32'h1);
    chk("R5 irq0 drops", 32'(irq), 32'h4);
    rd(A_ST, 4, 0, "R5 status after clear");

    // R6 set beats clear
    wr(A_CNT, 6);
    wr(A_ST, 32'h4, 1'b1);
    chk("R6 irq2 stays", 32'(irq), 32'h4);
    rd(A_CNT, 7, 0, "R6 counter advanced");
    wr(A_ST, 32'h4);
    rd(A_ST, 0, 0, "R5 plain clear");

    // R2 wrap
    wr(A_CNT, 32'hFFFF_FFFE);
    tick(2);
    rd(A_CNT, 0, 0, "R2 wrap");

    // R3 load is not a match; load beats tick
    wr(A_CNT, 5);
    rd(A_ST, 0, 0, "R3 load no match");
    wr(A_CNT, 20, 1'b1);
    rd(A_CNT, 20, 0, "R3 load overrides tick");
    tick(1);
    rd(A_CNT, 21, 0, "R3 counts on from load");

    // R7 watchdog
    wr(A_WD, 1);
    wr(A_CNT, 98);
    tick(1);
    chk("R7 no early request", 32'(rst_req), 0);
    tick(1);
    chk("R7 request", 32'(rst_req), 1);
    @(negedge clk);
    chk("R7 single cycle", 32'(rst_req), 0);
    rd(A_WD, 0, 0, "R7 disarmed");
    rd(A_ST, 0, 0, "R4 ch3 gated off");
    wr(A_CNT, 98);
    tick(2);
    @(negedge clk);
    chk("R7 pulse count", 32'(wd_pulses), 1);

    // R10 unmapped
    rd(A_IE, 5, 0, "R10 prior read");
    rd(8'h24, 0, 1, "R10 unmapped read");
    rd(8'h02, 0, 1, "R10 misaligned read");
    rd(A_M3, 100, 0, "R10 err clears");
    wr(8'h24, 32'hFFFF_FFFF);
    rd(A_IE, 5, 0, "R10 write ignored inten");
    rd(A_CNT, 100, 0, "R10 write ignored counter");
    rd(A_WD, 0, 0, "R10 write ignored wdarm");

    @(negedge clk);
    chk("scoreboard drained", 32'(sb.size()), 0);
    finish_run();
  end
endmodule